// File: doc/BRIEF.md
# Read-Side Slave with Registered Address Ready and One-Entry Skid Store

This block is the read half of a simple memory-mapped slave. It takes single-beat read requests on an address channel and answers each with one data beat on a response channel. The data comes from a small internal table of sixteen words, and each response carries the ID of its request.

The address-ready output comes straight from a flip-flop, so it never depends on the response-ready input within the same cycle. Because of that register, the slave learns of a response stall one cycle late. In that cycle it may still accept one request. That request is parked in a one-entry skid store instead of being dropped, and address-ready then falls until the store drains.

This arrangement keeps one request and one response per clock while the master keeps response-ready high. Request order is kept across stalls.

Top module: `axi_rd_skid_slave`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `rValid`=0 and `arReady`=0. On the first clock edge with `rst` low, `arReady` becomes 1.
- R2: `arReady` is a registered output. It is low in every cycle in which a request is parked in the skid store.
- R3: With `rReady` held high, a request accepted at a clock edge appears as a valid response right after that same edge. One request is accepted and one beat is delivered on every clock.
- R4: While `rValid`=1 and `rReady`=0, the next cycle still shows `rValid`=1 with `rData` and `rId` unchanged.
- R5: A request accepted while the response channel is stalled (`rValid`=1, `rReady`=0) is held in the skid store. It is not lost.
- R6: While the skid store is occupied and `rReady` stays low, no further request is accepted (`arReady`=0).
- R7: When `rReady` returns high, the parked request is answered next, before any new request is accepted. Responses therefore come out in request order.
- R8: `rData` equals the table word at index `arAddr[5:2]`, where word i = 0xC0DE0000 | (i*0x111). `rId` echoes the request's `arId`. `rResp` is 2'b00 (OKAY) and `rLast` is 1.
- R9: `rValid` rises after an accepted request even while `rReady` is held low. A response never waits on `rReady`.
- R10: With no request accepted and no beat pending, `rValid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arValid | input | 1 | Read request valid |
| arReady | output | 1 | Registered read request ready |
| arAddr | input | ADDR_W | Read byte address |
| arId | input | ID_W | Request ID |
| rValid | output | 1 | Response valid |
| rReady | input | 1 | Response ready from master |
| rData | output | DATA_W | Response data word |
| rId | output | ID_W | Response ID |
| rResp | output | 2 | Response code, always OKAY |
| rLast | output | 1 | Last beat flag, always 1 |

## Verification
Every output is one register deep from its cause. A response for a request accepted at edge k is visible right after edge k. A parked request shows up one edge after `rReady` returns. `arReady` falls one edge after a request is parked and rises one edge after the store drains. The bench sets inputs just after a rising edge, lets exactly one edge pass, and samples one nanosecond after it. Each check is therefore tied to a known edge count, and none depends on the order in which processes run at an edge.

// File: rtl/rd_skid_pkg.sv
package rd_skid_pkg;

  typedef struct packed {
    logic loadAr;       // response register takes the live request
    logic loadSkid;     // response register takes the parked request
    logic captureSkid;  // skid store takes the live request
  } rdStrobe_t;

  function automatic logic [31:0] tableWord(input int idx);
    return 32'hC0DE_0000 | 32'(idx * 32'h111);
  endfunction

endpackage

// File: rtl/rd_skid_ctrl.sv
module rd_skid_ctrl
  import rd_skid_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      arValid,
  input  logic      rReady,
  output logic      arReady,
  output logic      rValid,
  output rdStrobe_t strb
);

  logic skidValid;
  logic skidNext;
  logic rValidNext;
  logic arFire;
  logic rFree;

  always_comb begin
    arFire     = arValid && arReady;
    rFree      = !rValid || rReady;
    strb       = '0;
    skidNext   = skidValid;
    rValidNext = rValid;
    if (rFree) begin
      if (skidValid) begin
        strb.loadSkid = 1'b1;
        rValidNext    = 1'b1;
        skidNext      = 1'b0;
      end else if (arFire) begin
        strb.loadAr = 1'b1;
        rValidNext  = 1'b1;
      end else begin
        rValidNext = 1'b0;
      end
    end else if (arFire) begin
      strb.captureSkid = 1'b1;
      skidNext         = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rValid    <= 1'b0;
      skidValid <= 1'b0;
      arReady   <= 1'b0;
    end else begin
      rValid    <= rValidNext;
      skidValid <= skidNext;
      arReady   <= !skidNext;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!rValid && !arReady));

  p_skid_blocks_ar_r2: assert property (@(posedge clk) disable iff (rst)
    skidValid |-> !arReady);

  p_accept_beat_r3: assert property (@(posedge clk) disable iff (rst)
    (arFire && rFree && !skidValid) |=> rValid);

  p_rvalid_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rValid && !rReady) |=> rValid);

  p_stall_park_r5: assert property (@(posedge clk) disable iff (rst)
    (arFire && rValid && !rReady) |=> skidValid);

  p_no_second_r6: assert property (@(posedge clk) disable iff (rst)
    (skidValid && !rReady) |=> (skidValid && !arReady));

  p_skid_first_r7: assert property (@(posedge clk) disable iff (rst)
    (skidValid && rReady) |=> (!skidValid && rValid));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!rValid && !arFire && !skidValid) |=> !rValid);

endmodule

// File: rtl/rd_skid_datapath.sv
module rd_skid_datapath
  import rd_skid_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ID_W    = 4,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 16,
  parameter int IDX_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  rdStrobe_t         strb,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic [ID_W-1:0]   arId,
  input  logic              rValid,
  input  logic              rReady,
  output logic [DATA_W-1:0] rData,
  output logic [ID_W-1:0]   rId
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] wordTable [DEPTH];
  logic [IDX_W-1:0]  arIdx;
  logic [IDX_W-1:0]  skidIdx;
  logic [ID_W-1:0]   skidId;

  assign arIdx = arAddr[IDX_LSB +: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        wordTable[i] <= DATA_W'(tableWord(i));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      skidIdx <= '0;
      skidId  <= '0;
    end else if (strb.captureSkid) begin
      skidIdx <= arIdx;
      skidId  <= arId;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rData <= '0;
      rId   <= '0;
    end else if (strb.loadSkid) begin
      rData <= wordTable[skidIdx];
      rId   <= skidId;
    end else if (strb.loadAr) begin
      rData <= wordTable[arIdx];
      rId   <= arId;
    end
  end

  p_payload_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (rValid && !rReady) |=> ($stable(rData) && $stable(rId)));

  p_single_load_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadAr, strb.loadSkid, strb.captureSkid}));

endmodule

// File: rtl/axi_rd_skid_slave.sv
module axi_rd_skid_slave
  import rd_skid_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arValid,
  output logic              arReady,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic [ID_W-1:0]   arId,
  output logic              rValid,
  input  logic              rReady,
  output logic [DATA_W-1:0] rData,
  output logic [ID_W-1:0]   rId,
  output logic [1:0]        rResp,
  output logic              rLast
);

  rdStrobe_t strb;

  rd_skid_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .arValid (arValid),
    .rReady  (rReady),
    .arReady (arReady),
    .rValid  (rValid),
    .strb    (strb)
  );

  rd_skid_datapath #(
    .ADDR_W  (ADDR_W),
    .ID_W    (ID_W),
    .DATA_W  (DATA_W),
    .DEPTH   (DEPTH),
    .IDX_LSB (2)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .arAddr (arAddr),
    .arId   (arId),
    .rValid (rValid),
    .rReady (rReady),
    .rData  (rData),
    .rId    (rId)
  );

  assign rResp = 2'b00;
  assign rLast = 1'b1;

endmodule

// File: tb/tb_axi_rd_skid_slave.sv
module tb_axi_rd_skid_slave;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arValid = 1'b0;
  logic        arReady;
  logic [7:0]  arAddr = '0;
  logic [3:0]  arId = '0;
  logic        rValid;
  logic        rReady = 1'b0;
  logic [31:0] rData;
  logic [3:0]  rId;
  logic [1:0]  rResp;
  logic        rLast;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  axi_rd_skid_slave dut (
    .clk(clk), .rst(rst), .arValid(arValid), .arReady(arReady),
    .arAddr(arAddr), .arId(arId), .rValid(rValid), .rReady(rReady),
    .rData(rData), .rId(rId), .rResp(rResp), .rLast(rLast)
  );

  function automatic logic [31:0] expWord(input int i);
    return 32'hC0DE_0000 | 32'(i * 32'h111);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic request(input int idx, input int id);
    arValid = 1'b1;
    arAddr  = 8'(idx << 2);
    arId    = 4'(id);
  endtask

  task automatic tReset();
    rst = 1'b1;
    repeat (3) tick();
    chk("R1 rValid in reset", 64'(rValid), 64'd0);
    chk("R1 arReady in reset", 64'(arReady), 64'd0);
    rst = 1'b0;
    tick();
    chk("R1 arReady after release", 64'(arReady), 64'd1);
  endtask

  task automatic tIdle();
    rReady  = 1'b1;
    arValid = 1'b0;
    repeat (3) tick();
    chk("R10 rValid idle", 64'(rValid), 64'd0);
    chk("R2 arReady idle", 64'(arReady), 64'd1);
  endtask

  task automatic tStream();
    rReady = 1'b1;
    for (int i = 0; i < 16; i++) begin
      request(i, (i * 5) & 15);
      chk("R3 arReady streaming", 64'(arReady), 64'd1);
      tick();
      chk("R3 rValid streaming", 64'(rValid), 64'd1);
      chk("R8 rData", 64'(rData), 64'(expWord(i)));
      chk("R8 rId", 64'(rId), 64'((i * 5) & 15));
      chk("R8 rResp", 64'(rResp), 64'd0);
      chk("R8 rLast", 64'(rLast), 64'd1);
    end
    arValid = 1'b0;
    tick();
    chk("R10 rValid after stream", 64'(rValid), 64'd0);
  endtask

  task automatic tStall();
    rReady = 1'b0;
    request(3, 5);
    tick();
    chk("R9 rValid without rReady", 64'(rValid), 64'd1);
    chk("R8 stall first data", 64'(rData), 64'(expWord(3)));
    chk("R2 arReady skid empty", 64'(arReady), 64'd1);
    request(7, 6);
    tick();
    chk("R2 arReady after park", 64'(arReady), 64'd0);
    request(9, 7);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R6 no second accept", 64'(arReady), 64'd0);
      chk("R4 rValid held", 64'(rValid), 64'd1);
      chk("R4 rData held", 64'(rData), 64'(expWord(3)));
      chk("R4 rId held", 64'(rId), 64'd5);
    end
    rReady = 1'b1;
    tick();
    chk("R5 parked beat valid", 64'(rValid), 64'd1);
    chk("R5 parked data", 64'(rData), 64'(expWord(7)));
    chk("R7 parked id first", 64'(rId), 64'd6);
    chk("R2 arReady after drain", 64'(arReady), 64'd1);
    tick();
    chk("R7 next request data", 64'(rData), 64'(expWord(9)));
    chk("R7 next request id", 64'(rId), 64'd7);
    arValid = 1'b0;
    tick();
    chk("R10 rValid after drain", 64'(rValid), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    tReset();
    tIdle();
    tStream();
    tStall();
    tIdle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule